// File: doc/BRIEF.md
# PID-Selected Memory Block Copier

This block moves a fixed-length block of words from one of three per-process source memories into a main memory. It is used when a process is scheduled: its working set is brought into the memory that the processor actually executes from. A 2-bit process identifier picks the source. The identifier is turned into a one-hot select, and that select steers a word multiplexer. The memory arrays themselves sit outside the block. The block drives one address that all sources and the main memory share, a write enable for the main memory, and the word to be written.

A single-cycle copy pulse arms the engine and captures the selected source. On each of the following clocks one word is written to the same address in main memory, and a 3-bit address counter advances. After eight words a done flip-flop sets. It freezes the counter, and the address falls back to zero. Further clocks do nothing until the next copy pulse. Identifier 0 means that no process owns the copy, so a pulse with identifier 0 arms nothing and writes nothing.

Top module: `pid_block_copier`

## Requirements
- R1: While reset is held, and in the first cycle after reset, the write enable is 0 and the address is 0.
- R2: A copy pulse with identifier k (1, 2 or 3) makes the write data equal to source bus k (src1, src2, src3) in every write cycle.
- R3: After a copy pulse with a non-zero identifier, the write enable is 1 for exactly 8 consecutive cycles. The first of these is the cycle after the pulse, and the address reads 0,1,...,7 in ascending order across them.
- R4: Once the eighth word has been written, the write enable stays 0 and the address stays 0 on every further clock until a new copy pulse arrives.
- R5: A copy pulse with identifier 0 causes no write cycle, and the main memory is left unchanged.
- R6: A copy pulse that arrives during a burst restarts the burst from address 0, using the identifier given with the new pulse, and then runs the full 8 words.
- R7: Whenever the write enable is 0, the address is 0.
- R8: A change of the identifier input during a burst has no effect. The source captured at the copy pulse is kept until the burst ends.
- R9: The captured source select is one-hot while the write enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| copy_i | input | 1 | Copy request pulse, one cycle high |
| pid_i | input | 2 | Process identifier; 0 selects no source |
| src1_data_i | input | 16 | Word read from source memory 1 at addr_o |
| src2_data_i | input | 16 | Word read from source memory 2 at addr_o |
| src3_data_i | input | 16 | Word read from source memory 3 at addr_o |
| addr_o | output | 3 | Address shared by the sources and the main memory |
| wr_en_o | output | 1 | Main-memory write enable |
| wr_data_o | output | 16 | Word to be written to main memory at addr_o |

## Verification
The properties assume the following about the inputs:
- Reset is asserted before the first clock, and copy_i is low while reset is held.
- Every identifier value is legal, which holds because the 2-bit field covers exactly the idle code and the three sources.
- The source buses are combinational reads at addr_o.

The bench keeps to these assumptions:
- It releases reset with copy_i low.
- It raises copy_i for one cycle at a time, on the falling edge.
- It computes each source bus from its own arrays at the current address.
- It changes pid_i only away from the rising edge, including the change made mid-burst to exercise R8.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_IDLE  = 2'b01,
    CMD_START = 2'b11
  } copy_cmd_t;

  function automatic copy_cmd_t classify_request(input logic req, input logic has_src);
    if (!req)        return CMD_NONE;
    else if (has_src) return CMD_START;
    else             return CMD_IDLE;
  endfunction

endpackage

// File: rtl/pbc_pid_decoder.sv
module pbc_pid_decoder #(
  parameter int PID_W   = 2,
  parameter int NUM_SRC = 3
) (
  input  logic [PID_W-1:0]   pid_i,
  output logic [NUM_SRC-1:0] onehot_o,
  output logic               any_o
);

  function automatic logic pid_hits(input logic [PID_W-1:0] pid, input int idx);
    return pid == PID_W'(idx + 1);
  endfunction

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_line
    assign onehot_o[k] = pid_hits(pid_i, k);
  end

  assign any_o = |onehot_o;

endmodule

// File: rtl/pbc_src_mux.sv
module pbc_src_mux #(
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 16
) (
  input  logic [NUM_SRC-1:0]             sel_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]              data_o
);

  logic [NUM_SRC-1:0][DATA_W-1:0] gated;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gate
    assign gated[k] = data_i[k] & {DATA_W{sel_i[k]}};
  end

  always_comb begin
    data_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      data_o = data_o | gated[k];
    end
  end

endmodule

// File: rtl/pbc_burst_ctrl.sv
module pbc_burst_ctrl
  import pbc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  copy_cmd_t         cmd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              move_o,
  output logic              last_beat_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == LAST_ADDR) ? '0 : a + ADDR_W'(1);
  endfunction

  logic              armed_q;
  logic              done_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              count_en;

  assign count_en    = armed_q & ~done_q;
  assign last_beat_o = count_en && (cnt_q == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (cmd_i)
        CMD_START: begin
          armed_q <= 1'b1;
          done_q  <= 1'b0;
          cnt_q   <= '0;
        end
        CMD_IDLE: begin
          armed_q <= 1'b0;
          done_q  <= 1'b0;
          cnt_q   <= '0;
        end
        default: begin
          if (count_en) begin
            cnt_q <= step_addr(cnt_q);
            if (last_beat_o) done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign addr_o = cnt_q;
  assign move_o = count_en;
  assign done_o = done_q;

endmodule

// File: rtl/pid_block_copier.sv
module pid_block_copier
  import pbc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int PID_W   = 2,
  parameter int NUM_SRC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              copy_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [DATA_W-1:0] src1_data_i,
  input  logic [DATA_W-1:0] src2_data_i,
  input  logic [DATA_W-1:0] src3_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic [NUM_SRC-1:0]             dec_onehot;
  logic                           dec_any;
  logic [NUM_SRC-1:0]             sel_q;
  logic [NUM_SRC-1:0][DATA_W-1:0] src_bus;
  copy_cmd_t                      cmd;
  logic                           burst_start;
  logic                           last_beat;
  logic                           done_flag;
  logic                           move;

  assign src_bus[0] = src1_data_i;
  assign src_bus[1] = src2_data_i;
  assign src_bus[2] = src3_data_i;

  pbc_pid_decoder #(.PID_W(PID_W), .NUM_SRC(NUM_SRC)) u_dec (
    .pid_i    (pid_i),
    .onehot_o (dec_onehot),
    .any_o    (dec_any)
  );

  assign cmd         = classify_request(copy_i, dec_any);
  assign burst_start = (cmd == CMD_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (copy_i)  sel_q <= dec_onehot;
  end

  pbc_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .addr_o      (addr_o),
    .move_o      (move),
    .last_beat_o (last_beat),
    .done_o      (done_flag)
  );

  pbc_src_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_mux (
    .sel_i  (sel_q),
    .data_i (src_bus),
    .data_o (wr_data_o)
  );

  assign wr_en_o = move;

endmodule

// File: rtl/pbc_copier_chk.sv
module pbc_copier_chk #(
  parameter int ADDR_W  = 3,
  parameter int PID_W   = 2,
  parameter int NUM_SRC = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               copy_i,
  input logic [PID_W-1:0]   pid_i,
  input logic [ADDR_W-1:0]  addr_o,
  input logic               wr_en_o,
  input logic [NUM_SRC-1:0] sel_q,
  input logic               burst_start,
  input logic               last_beat,
  input logic               done_flag
);

  AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !copy_i && !last_beat) |=> (wr_en_o && addr_o == $past(addr_o) + ADDR_W'(1))); // R3

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !copy_i) |=> (!wr_en_o && addr_o == '0 && done_flag)); // R4

  AST_STAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_o && !copy_i) |=> !wr_en_o); // R4

  AST_NO_SRC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_i && pid_i == '0) |=> !wr_en_o); // R5

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (wr_en_o && addr_o == '0)); // R6

  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_o |-> addr_o == '0); // R7

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !copy_i) |=> $stable(sel_q)); // R8

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $countones(sel_q) == 1); // R9

endmodule

bind pid_block_copier pbc_copier_chk #(
  .ADDR_W(ADDR_W), .PID_W(PID_W), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .copy_i      (copy_i),
  .pid_i       (pid_i),
  .addr_o      (addr_o),
  .wr_en_o     (wr_en_o),
  .sel_q       (sel_q),
  .burst_start (burst_start),
  .last_beat   (last_beat),
  .done_flag   (done_flag)
);

// File: tb/tb_pid_block_copier.sv
`timescale 1ns/1ps
module tb_pid_block_copier;

  localparam int DW = 16;
  localparam int WORDS = 8;
  localparam logic [DW-1:0] SENTINEL = 16'hDEAD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          copy_i = 1'b0;
  logic [1:0]    pid_i = 2'd0;
  logic [DW-1:0] src1, src2, src3;
  logic [2:0]    addr_o;
  logic          wr_en_o;
  logic [DW-1:0] wr_data_o;

  logic [DW-1:0] src_mem [3][WORDS];
  logic [DW-1:0] main_mem [WORDS];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pid_block_copier dut (
    .clk(clk), .rst_n(rst_n), .copy_i(copy_i), .pid_i(pid_i),
    .src1_data_i(src1), .src2_data_i(src2), .src3_data_i(src3),
    .addr_o(addr_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
  );

  function automatic logic [DW-1:0] word_of(input int p, input int a);
    return DW'(p * 16'h1111 + a * 16'h0013 + 16'h0100);
  endfunction

  assign src1 = src_mem[0][addr_o];
  assign src2 = src_mem[1][addr_o];
  assign src3 = src_mem[2][addr_o];

  always @(posedge clk) if (wr_en_o) main_mem[addr_o] <= wr_data_o;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill_main();
    for (int a = 0; a < WORDS; a++) main_mem[a] = SENTINEL;
  endtask

  task automatic pulse_copy(input logic [1:0] p);
    @(negedge clk); copy_i = 1'b1; pid_i = p;
    @(negedge clk); copy_i = 1'b0;
  endtask

  task automatic check_beat(input int p, input int i);
    check("R3 wr_en", {31'd0, wr_en_o}, 32'd1);
    check("R3 addr", {29'd0, addr_o}, i);
    check("R2 data", {16'd0, wr_data_o}, {16'd0, word_of(p, i)});
  endtask

  task automatic check_idle(input string req, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      check({req, " wr_en"}, {31'd0, wr_en_o}, 32'd0);
      check("R7 addr", {29'd0, addr_o}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic check_main(input string req, input int p);
    for (int a = 0; a < WORDS; a++)
      check(req, {16'd0, main_mem[a]}, {16'd0, (p == 0) ? SENTINEL : word_of(p, a)});
  endtask

  // vector: {pid, expected write beats}
  localparam logic [5:0] VEC [6] = '{
    {2'd1, 4'd8}, {2'd2, 4'd8}, {2'd3, 4'd8},
    {2'd0, 4'd0}, {2'd3, 4'd8}, {2'd1, 4'd8}
  };

  initial begin
    #1_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < WORDS; a++) src_mem[p][a] = word_of(p + 1, a);
    fill_main();

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 wr_en in reset", {31'd0, wr_en_o}, 32'd0);
    check("R1 addr in reset", {29'd0, addr_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wr_en after reset", {31'd0, wr_en_o}, 32'd0);
    check("R1 addr after reset", {29'd0, addr_o}, 32'd0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      int p, beats;
      p = int'(VEC[v][5:4]);
      beats = int'(VEC[v][3:0]);
      fill_main();
      pulse_copy(VEC[v][5:4]);
      if (beats == 0) begin
        check_idle("R5", 10);
        check_main("R5 main untouched", 0);
      end else begin
        for (int i = 0; i < beats; i++) begin
          check_beat(p, i);
          @(negedge clk);
        end
        check_idle("R4", 6);
        check_main("R2 main contents", p);
      end
    end

    // R8: identifier changes mid-burst
    fill_main();
    pulse_copy(2'd1);
    for (int i = 0; i < WORDS; i++) begin
      check_beat(1, i);
      if (i == 2) pid_i = 2'd3;
      if (i == 5) pid_i = 2'd0;
      @(negedge clk);
    end
    check_idle("R8", 3);
    check_main("R8 main contents", 1);

    // R4: further clocks with changing identifier do nothing
    pid_i = 2'd2;
    check_idle("R4 after done", 5);
    check_main("R4 main unchanged", 1);

    // R6: restart during a burst
    fill_main();
    pulse_copy(2'd2);
    for (int i = 0; i < 3; i++) begin
      check_beat(2, i);
      @(negedge clk);
    end
    pulse_copy(2'd3);
    for (int i = 0; i < WORDS; i++) begin
      check_beat(3, i);
      @(negedge clk);
    end
    check_idle("R6", 3);
    check_main("R6 main contents", 3);

    // R1: reset in mid-burst
    pulse_copy(2'd2);
    check_beat(2, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 wr_en on reset", {31'd0, wr_en_o}, 32'd0);
    check("R1 addr on reset", {29'd0, addr_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1", 4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule